// File: doc/BRIEF.md
# Configurable Eight-Pin I/O Port with Peripheral Handover

This block drives one bank of general-purpose pins. Each pin can be configured by software as a push-pull output, an open-drain output, an input, or as a pin lent to an on-chip peripheral. Software configures the bank through three byte-wide control registers: a mode byte, a drive-style byte and an output-data byte. A fourth byte reports the level sampled on the pads. All four sit on a simple write-strobe register bus with a combinational read path.

When a pin is lent to a peripheral, the peripheral's per-pin value and enable pass straight to the pad. Writes to the output-data byte are still stored, but they do not appear on the pin until the pin returns to port control. Software can therefore preload a safe level before it takes a pin back from the peripheral.

Top module: `gpio_port`

## Requirements
- R1: After reset the drive-style byte reads 0xFF, the output-data byte reads 0xFF, the mode byte reads 0x00, the pin-status byte reads 0x00, and no pad output enable is asserted.
- R2: The register offsets are: mode at 0, drive style at 2, output data at 4 and pin status at 6. A write takes effect at the clock edge on which the write strobe is high. Odd offsets read as 0x00, and writes to them change nothing.
- R3: A pin with mode bit 0 and drive-style bit 0 is push-pull. Its output enable is 1 and its pad value equals its output-data bit from the clock edge that stores the write.
- R4: A pin with mode bit 0 and drive-style bit 1 is open-drain. With data bit 0 the pad is enabled and driven low. With data bit 1 the enable is 0, which leaves the pin free to act as an input.
- R5: A pin with mode bit 1 takes its pad value and output enable from the peripheral's per-pin value and enable inputs.
- R6: Writes to the output-data byte are stored and read back while pins are lent to the peripheral, but they leave those pads unchanged. Clearing the mode bit then drives the stored value.
- R7: The pin-status byte shows the pad input levels through a two-stage synchronizer: a change appears after the second clock edge and not after the first, whatever the pin's configuration.
- R8: Bus writes to the pin-status offset have no effect on what that byte reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed offset (combinational) |
| fn_out | input | 8 | Peripheral value per pin |
| fn_oe | input | 8 | Peripheral output enable per pin |
| pad_out | output | 8 | Value toward each pad |
| pad_oe | output | 8 | Output enable toward each pad |
| pad_in | input | 8 | Level sampled from each pad |

## Verification
The drive logic is tried with alternating, complementary and nibble-split data bytes. Each byte puts the port in a different condition:
- With all pins push-pull, these bytes show whether the value path is mapped bit for bit.
- With all pins open-drain, the same kind of bytes show whether enable and value are swapped or inverted.
- A split mode byte with varied peripheral signals shows whether each pin selects its source independently of its neighbours.
- A data write while the pins are lent out, followed by handing them back, separates "stored" from "driven".
- Pad input steps are sampled one and two edges after the change, which pins the synchronizer depth to exactly two.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [2:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] fn_out,
  input  logic [W-1:0] fn_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  input  logic [W-1:0] pad_in
);
  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_DIR  = 3'd2;
  localparam logic [2:0] A_DATA = 3'd4;
  localparam logic [2:0] A_PIN  = 3'd6;

  logic [W-1:0] mode_q, dir_q, data_q, sync1_q, stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '1;
      data_q <= '1;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MODE:  mode_q <= bus_wdata;
        A_DIR:   dir_q  <= bus_wdata;
        A_DATA:  data_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      stat_q  <= '0;
    end else begin
      sync1_q <= pad_in;
      stat_q  <= sync1_q;
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = mode_q;
      A_DIR:   bus_rdata = dir_q;
      A_DATA:  bus_rdata = data_q;
      A_PIN:   bus_rdata = stat_q;
      default: bus_rdata = '0;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pad_oe[i]  = mode_q[i] ? fn_oe[i]  : (~dir_q[i] | ~data_q[i]);
    assign pad_out[i] = mode_q[i] ? fn_out[i] : (~dir_q[i] & data_q[i]);
  end

  assert_pp_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DATA) |=>
      ((pad_out & ~mode_q & ~dir_q) == ($past(bus_wdata) & ~mode_q & ~dir_q)));

  assert_od_never_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & pad_oe & ~mode_q & dir_q) == '0));

  assert_fn_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_out ^ fn_out) & mode_q) == '0) && (((pad_oe ^ fn_oe) & mode_q) == '0));

  assert_pin_wr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PIN) |=> (stat_q == $past(sync1_q)));
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  logic       clk = 0, rst_n = 0, bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, fn_out = 0, fn_oe = 0, pad_in = 0;
  logic [7:0] bus_rdata, pad_out, pad_oe;
  logic [7:0] m_mode, m_dir, m_data;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  gpio_port u0 (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
                .fn_out, .fn_oe, .pad_out, .pad_oe, .pad_in);

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk); bus_wr = 0;
    if (a == 0) m_mode = d;
    if (a == 2) m_dir = d;
    if (a == 4) m_data = d;
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [7:0] exp);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic chk_pads(string tag);
    logic [7:0] eo, ev;
    for (int i = 0; i < 8; i++) begin
      eo[i] = m_mode[i] ? fn_oe[i]  : (!m_dir[i] || !m_data[i]);
      ev[i] = m_mode[i] ? fn_out[i] : (!m_dir[i] && m_data[i]);
    end
    #1;
    chk({tag, " oe"}, pad_oe, eo);
    chk({tag, " out"}, pad_out, ev);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rd("R1 dir", 2, 8'hFF); rd("R1 data", 4, 8'hFF);
    rd("R1 mode", 0, 8'h00); rd("R1 pin", 6, 8'h00);
    chk("R1 oe", pad_oe, 8'h00);
  endtask

  task automatic t_map;
    wr(2, 8'h3C); rd("R2 dir readback", 2, 8'h3C);
    for (int a = 1; a < 8; a += 2) wr(3'(a), 8'h00);
    rd("R2 dir kept", 2, 8'h3C); rd("R2 data kept", 4, 8'hFF);
    rd("R2 mode kept", 0, 8'h00);
    for (int a = 1; a < 8; a += 2) rd("R2 odd read", 3'(a), 8'h00);
    chk_pads("R2 pads");
  endtask

  task automatic t_pushpull;
    wr(2, 8'h00);
    wr(4, 8'h55); chk_pads("R3 55");
    wr(4, 8'hAA); chk_pads("R3 AA");
    wr(4, 8'h0F); chk_pads("R3 0F");
    chk("R3 all enabled", pad_oe, 8'hFF);
  endtask

  task automatic t_opendrain;
    wr(2, 8'hFF);
    wr(4, 8'h5A); chk_pads("R4 5A");
    chk("R4 oe", pad_oe, 8'hA5); chk("R4 low", pad_out, 8'h00);
    wr(4, 8'hFF); chk("R4 released", pad_oe, 8'h00);
  endtask

  task automatic t_special;
    wr(2, 8'h00); wr(4, 8'h0F);
    wr(0, 8'hF0);
    @(negedge clk); fn_out = 8'hA5; fn_oe = 8'h3C; chk_pads("R5 mix1");
    @(negedge clk); fn_out = 8'h5A; fn_oe = 8'hC3; chk_pads("R5 mix2");
    chk("R5 low nibble kept", pad_out[3:0], 4'hF);
  endtask

  task automatic t_hold;
    @(negedge clk); fn_out = 8'h00; fn_oe = 8'hFF;
    wr(0, 8'hFF); wr(4, 8'h33);
    rd("R6 stored", 4, 8'h33);
    chk("R6 pad unchanged", pad_out, 8'h00);
    wr(0, 8'h00);
    chk("R6 revealed", pad_out, 8'h33); chk_pads("R6 pads");
  endtask

  task automatic t_sync;
    @(negedge clk); pad_in = 8'hC3; bus_addr = 6;
    @(posedge clk); @(negedge clk); rd("R7 one edge", 6, 8'h00);
    @(posedge clk); @(negedge clk); rd("R7 two edges", 6, 8'hC3);
    pad_in = 8'h96;
    @(posedge clk); @(posedge clk); @(negedge clk); rd("R7 second step", 6, 8'h96);
  endtask

  task automatic t_pinwr;
    wr(6, 8'h00); rd("R8 write ignored", 6, 8'h96);
    wr(6, 8'hFF); rd("R8 write ignored 2", 6, 8'h96);
  endtask

  initial begin
    m_mode = 8'h00; m_dir = 8'hFF; m_data = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset; t_map; t_pushpull; t_opendrain; t_special; t_hold; t_sync; t_pinwr;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule